// File: doc/BRIEF.md
# Power-Fail Autostore and Recall Controller

This controller sequences the nonvolatile transfers of a shadowed SRAM. It watches two digital supply flags, both already produced by analog sensing outside the block. The first says the supply is under the switch level. The second says it has fallen further, under the reset level. The controller also accepts single-cycle store and recall requests from a software sequence detector, and a write strobe from the SRAM access path.

A store drives an erase phase and then a program phase. A recall drives a clear phase and then a transfer phase. Each phase output tells the array logic what to do in that cycle. While a transfer runs, `busy` is high and `mem_off` blocks all SRAM traffic. Phase lengths are counted in clock cycles and set by parameters. The first half of each total goes to the first phase and the rest to the second.

The controller keeps a dirty flag for unsaved SRAM writes. An automatic store on supply loss happens only when that flag is set. It also keeps a pending-recall latch, which is armed by a deep supply dip and released when the supply recovers.

Top module: `nvseq_ctrl`

## Requirements
- R1: After reset, and immediately on asserting `rst_n` low even in the middle of an operation, all four phase outputs, `busy` and `mem_off` are low (with `sup_low` low), and the dirty flag and pending-recall latch are cleared.
- R2: A store drives `ph_erase` for STORE_CYC/2 cycles (rounded down), then `ph_program` for the remaining cycles, then returns to idle. The first erase cycle is the one right after the triggering clock edge.
- R3: A write strobe accepted while idle, with `sup_low` low, sets the dirty flag. While idle with the dirty flag set and no recall pending, `sup_low` high starts a store at the next edge.
- R4: With the dirty flag clear, `sup_low` high starts no store.
- R5: `sw_store_req` starts a store whether or not the dirty flag is set. The request is ignored while `sup_low` is high.
- R6: `sw_recall_req` while idle, with no recall pending, drives `ph_clear` for RECALL_CYC/2 cycles, then `ph_transfer` for the remainder.
- R7: `sup_dead` high latches a pending recall. While `sup_low` stays high no recall starts. On the first idle edge with `sup_low` low, a recall starts: clear for RESTORE_CYC/2 cycles, then transfer for the remainder.
- R8: A supply dip that raises `sup_low` but never `sup_dead` starts no recall when `sup_low` falls.
- R9: `busy` is high exactly while a phase output is high. `mem_off` is high when `busy` or `sup_low` is high.
- R10: Start priority in one idle cycle, from highest: pending recall (with `sup_low` low), then automatic store, then software store, then software recall.
- R11: Completing a store or a recall clears the dirty flag.
- R12: Requests and write strobes that arrive while busy are neither acted on nor kept. A started phase holds until its count runs out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sup_low | input | 1 | Supply below switch threshold |
| sup_dead | input | 1 | Supply below reset threshold |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| wr_strobe | input | 1 | One SRAM write accepted this cycle |
| ph_erase | output | 1 | Store phase 1: erase nonvolatile copy |
| ph_program | output | 1 | Store phase 2: program SRAM contents into nonvolatile copy |
| ph_clear | output | 1 | Recall phase 1: clear SRAM |
| ph_transfer | output | 1 | Recall phase 2: copy nonvolatile data into SRAM |
| mem_off | output | 1 | SRAM access disabled |
| busy | output | 1 | A store or recall is running |

## Verification
The hardest state to reach is the one where the dirty flag is set and a software recall request, a supply drop and the flag's own history all meet in the same idle cycle. The flag is not visible at the ports. The stimulus therefore sets it with a lone write strobe, clears it with completed stores and recalls, and then reads it back by lowering the supply and seeing whether an erase phase follows. The priority case raises `sup_low` and `sw_recall_req` together on a dirty memory. The deep-dip case holds `sup_low` high across the `sup_dead` pulse, so that the recall is seen to wait for recovery.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ERASE, S_PROG, S_CLEAR, S_XFER
  } nv_state_e;

  typedef enum logic [2:0] {
    K_NONE, K_AUTO_ST, K_SW_ST, K_PWR_RC, K_SW_RC
  } nv_kind_e;
endpackage

// File: rtl/nvseq_arb.sv
module nvseq_arb
  import nvseq_pkg::*;
(
  input  logic     idle,
  input  logic     sup_low,
  input  logic     dirty,
  input  logic     pend,
  input  logic     sw_st,
  input  logic     sw_rc,
  output nv_kind_e kind
);
  // R10: fixed priority among start causes
  always_comb begin
    kind = K_NONE;
    if (idle) begin
      if (pend && !sup_low)                kind = K_PWR_RC;
      else if (sup_low && dirty && !pend)  kind = K_AUTO_ST;
      else if (sw_st && !sup_low)          kind = K_SW_ST;
      else if (sw_rc && !pend)             kind = K_SW_RC;
    end
  end
endmodule

// File: rtl/nvseq_flags.sv
module nvseq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic sup_low,
  input  logic sup_dead,
  input  logic wr,
  input  logic done,
  input  logic pwr_start,
  output logic dirty,
  output logic pend
);
  logic dirty_d, pend_d;

  always_comb begin
    dirty_d = dirty;
    if (done)                          dirty_d = 1'b0;   // R11
    else if (wr && idle && !sup_low)   dirty_d = 1'b1;   // R3
    pend_d = pend;
    if (sup_dead)                      pend_d = 1'b1;    // R7
    else if (pwr_start)                pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= 1'b0;
      pend  <= 1'b0;
    end else begin
      dirty <= dirty_d;
      pend  <= pend_d;
    end
  end

  assert_pend_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && sup_low) |=> pend)
    else $error("pending recall lost while supply low");
endmodule

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int STORE_CYC   = 1000000,
  parameter int RECALL_CYC  = 65000,
  parameter int RESTORE_CYC = 55000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_low,
  input  logic sup_dead,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic wr_strobe,
  output logic ph_erase,
  output logic ph_program,
  output logic ph_clear,
  output logic ph_transfer,
  output logic mem_off,
  output logic busy
);
  localparam int ST1  = STORE_CYC / 2;
  localparam int ST2  = STORE_CYC - ST1;
  localparam int RC1  = RECALL_CYC / 2;
  localparam int RC2  = RECALL_CYC - RC1;
  localparam int RS1  = RESTORE_CYC / 2;
  localparam int RS2  = RESTORE_CYC - RS1;
  localparam int MX0  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAXC = (MX0 > RESTORE_CYC) ? MX0 : RESTORE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  nv_state_e     st_q, st_d;
  nv_kind_e      kind;
  logic          pwr_q, pwr_d;
  logic          ld, tmr_exp, done, pwr_start, idle, dirty, pend;
  logic [CW-1:0] ld_val;

  assign idle = (st_q == S_IDLE);

  nvseq_arb u_arb (
    .idle    (idle),
    .sup_low (sup_low),
    .dirty   (dirty),
    .pend    (pend),
    .sw_st   (sw_store_req),
    .sw_rc   (sw_recall_req),
    .kind    (kind)
  );

  nvseq_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_s),
    .idle      (idle),
    .sup_low   (sup_low),
    .sup_dead  (sup_dead),
    .wr        (wr_strobe),
    .done      (done),
    .pwr_start (pwr_start),
    .dirty     (dirty),
    .pend      (pend)
  );

  nvseq_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (ld),
    .load_val (ld_val),
    .expired  (tmr_exp)
  );

  always_comb begin
    st_d      = st_q;
    ld        = 1'b0;
    ld_val    = '0;
    done      = 1'b0;
    pwr_start = 1'b0;
    case (st_q)
      S_IDLE: begin
        case (kind)
          K_AUTO_ST, K_SW_ST: begin
            st_d = S_ERASE; ld = 1'b1; ld_val = CW'(ST1 - 1);
          end
          K_PWR_RC: begin
            st_d = S_CLEAR; ld = 1'b1; ld_val = CW'(RS1 - 1); pwr_start = 1'b1;
          end
          K_SW_RC: begin
            st_d = S_CLEAR; ld = 1'b1; ld_val = CW'(RC1 - 1);
          end
          default: ;
        endcase
      end
      S_ERASE: if (tmr_exp) begin
        st_d = S_PROG; ld = 1'b1; ld_val = CW'(ST2 - 1);
      end
      S_PROG: if (tmr_exp) begin
        st_d = S_IDLE; done = 1'b1;
      end
      S_CLEAR: if (tmr_exp) begin
        st_d = S_XFER; ld = 1'b1;
        ld_val = pwr_q ? CW'(RS2 - 1) : CW'(RC2 - 1);
      end
      S_XFER: if (tmr_exp) begin
        st_d = S_IDLE; done = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    pwr_d = pwr_q;
    if (idle) pwr_d = (kind == K_PWR_RC);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q  <= S_IDLE;
      pwr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pwr_q <= pwr_d;
    end
  end

  assign ph_erase    = (st_q == S_ERASE);
  assign ph_program  = (st_q == S_PROG);
  assign ph_clear    = (st_q == S_CLEAR);
  assign ph_transfer = (st_q == S_XFER);
  assign busy        = !idle;
  assign mem_off     = busy || sup_low;

  assert_erase_then_prog_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_ERASE) |=> (st_q inside {S_ERASE, S_PROG}))
    else $error("erase not followed by program");

  assert_clear_then_xfer_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_CLEAR) |=> (st_q inside {S_CLEAR, S_XFER}))
    else $error("clear not followed by transfer");

  assert_clean_no_store_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (idle && !dirty && !(sw_store_req && !sup_low)) |=> (st_q != S_ERASE))
    else $error("store started on clean memory");

  assert_no_recall_while_low_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (idle && pend && sup_low) |=> (st_q != S_CLEAR))
    else $error("recall started while supply low");

  assert_phase_hold_R12: assert property (@(posedge clk) disable iff (!rst_s)
    (!idle && !tmr_exp) |=> $stable(st_q))
    else $error("phase left before its count ran out");
endmodule

// File: tb/nvseq_ctrl_tb_top.sv
module nvseq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic sup_low, sup_dead, sw_store_req, sw_recall_req, wr_strobe;
  logic ph_erase, ph_program, ph_clear, ph_transfer, mem_off, busy;
  int   total = 0;
  int   bad   = 0;

  always #5 clk = ~clk;

  nvseq_ctrl #(.STORE_CYC(5), .RECALL_CYC(6), .RESTORE_CYC(4)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sup_low       (sup_low),
    .sup_dead      (sup_dead),
    .sw_store_req  (sw_store_req),
    .sw_recall_req (sw_recall_req),
    .wr_strobe     (wr_strobe),
    .ph_erase      (ph_erase),
    .ph_program    (ph_program),
    .ph_clear      (ph_clear),
    .ph_transfer   (ph_transfer),
    .mem_off       (mem_off),
    .busy          (busy)
  );

  // row: {sup_low,sup_dead,sw_store,sw_recall,wr} {erase,prog,clear,xfer,busy,mem_off} {req}
  localparam int NV = 54;
  localparam logic [14:0] VEC [NV] = '{
    {5'b00100, 6'b100011, 4'd5},   // R5 store on clean memory
    {5'b00000, 6'b100011, 4'd2},   // R2 erase 2 cycles
    {5'b00000, 6'b010011, 4'd2},
    {5'b00000, 6'b010011, 4'd2},
    {5'b00000, 6'b010011, 4'd2},   // R2 program 3 cycles
    {5'b00000, 6'b000000, 4'd2},
    {5'b10000, 6'b000001, 4'd4},   // R4 clean dip, no store
    {5'b10000, 6'b000001, 4'd4},
    {5'b00000, 6'b000000, 4'd8},   // R8 no recall after shallow dip
    {5'b00001, 6'b000000, 4'd3},   // R3 write sets dirty
    {5'b10000, 6'b100011, 4'd3},
    {5'b10000, 6'b100011, 4'd3},
    {5'b10000, 6'b010011, 4'd3},
    {5'b10000, 6'b010011, 4'd3},
    {5'b10000, 6'b010011, 4'd3},
    {5'b10000, 6'b000001, 4'd11},  // R11 store done, dirty cleared
    {5'b10000, 6'b000001, 4'd11},
    {5'b00000, 6'b000000, 4'd8},
    {5'b00100, 6'b100011, 4'd5},
    {5'b00001, 6'b100011, 4'd12},  // R12 write while busy
    {5'b00000, 6'b010011, 4'd2},
    {5'b00000, 6'b010011, 4'd2},
    {5'b00000, 6'b010011, 4'd2},
    {5'b00000, 6'b000000, 4'd2},
    {5'b10000, 6'b000001, 4'd12},  // R12 that write left memory clean
    {5'b00000, 6'b000000, 4'd9},
    {5'b00001, 6'b000000, 4'd3},
    {5'b00010, 6'b001011, 4'd6},   // R6 software recall, clear 3
    {5'b00000, 6'b001011, 4'd6},
    {5'b00000, 6'b001011, 4'd6},
    {5'b00000, 6'b000111, 4'd6},   // R6 transfer 3
    {5'b00000, 6'b000111, 4'd6},
    {5'b00000, 6'b000111, 4'd6},
    {5'b00000, 6'b000000, 4'd6},
    {5'b10000, 6'b000001, 4'd11},  // R11 recall cleared dirty
    {5'b00000, 6'b000000, 4'd9},
    {5'b00001, 6'b000000, 4'd3},
    {5'b10010, 6'b100011, 4'd10},  // R10 auto store beats recall
    {5'b10000, 6'b100011, 4'd10},
    {5'b10000, 6'b010011, 4'd10},
    {5'b10000, 6'b010011, 4'd10},
    {5'b10000, 6'b010011, 4'd10},
    {5'b10000, 6'b000001, 4'd10},
    {5'b00000, 6'b000000, 4'd10},
    {5'b10100, 6'b000001, 4'd5},   // R5 store ignored while low
    {5'b00000, 6'b000000, 4'd9},
    {5'b10000, 6'b000001, 4'd9},   // R9 mem_off follows sup_low
    {5'b11000, 6'b000001, 4'd7},   // R7 deep dip latches recall
    {5'b10000, 6'b000001, 4'd7},
    {5'b00000, 6'b001011, 4'd7},   // R7 recall on recovery
    {5'b00000, 6'b001011, 4'd7},
    {5'b00000, 6'b000111, 4'd7},
    {5'b00000, 6'b000111, 4'd7},
    {5'b00000, 6'b000000, 4'd7}
  };

  task automatic drive(input logic [4:0] v);
    {sup_low, sup_dead, sw_store_req, sw_recall_req, wr_strobe} = v;
  endtask

  task automatic step(input logic [4:0] v);
    drive(v);
    @(negedge clk);
  endtask

  task automatic chk(input logic [5:0] exp, input int req, input string what);
    logic [5:0] act;
    act = {ph_erase, ph_program, ph_clear, ph_transfer, busy, mem_off};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL R1 watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(5'b00000);
    repeat (3) @(negedge clk);
    chk(6'b000000, 1, "in reset");               // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(6'b000000, 1, "after reset release");    // R1

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14:10]);
      chk(VEC[i][9:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R10: software store wins over software recall
    step(5'b00110);
    chk(6'b100011, 10, "store over recall");
    repeat (5) step(5'b00000);
    chk(6'b000000, 10, "store over recall done");

    // R12: recall request during a store is dropped
    step(5'b00100);
    step(5'b00010);
    chk(6'b100011, 12, "recall during erase");
    repeat (4) step(5'b00000);
    chk(6'b000000, 12, "store finished");
    step(5'b00000);
    chk(6'b000000, 12, "no late recall");

    // R1: reset in the middle of a store
    step(5'b00100);
    chk(6'b100011, 1, "store running");
    drive(5'b00000);
    rst_n = 1'b0;
    #1;
    chk(6'b000000, 1, "reset mid store");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(6'b000000, 1, "idle after mid reset");
    // R1: dirty flag was cleared by reset
    step(5'b10000);
    chk(6'b000001, 1, "no store after reset");
    step(5'b00000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule